// File: doc/BRIEF.md
# Time Slot Interchange Switch Core

This block moves 8-bit channels between parallel time-division streams. In every channel time the byte arriving on each input stream is stored in a data memory. In the same channel time each output stream reads its own 13-bit connection word from a per-output-channel connection memory. The word either names a source stream and channel, whose byte from the previous frame is sent out, or it carries a fixed message byte. The five upper bits of the word select the mode, set the output driver enable, turn on loopback, carry a control bit and carry a delay-type flag for a downstream delay stage.

Channel timing comes from a one-cycle `slot_en` strobe that marks each channel time and an `fsync` pulse that marks channel 0 of a frame. A small state machine has two states. In `ST_HUNT` it waits for alignment. The transition `ST_HUNT -> ST_RUN` is taken on a strobe that has `fsync` high. `ST_RUN` then stays in `ST_RUN` and counts channels. It wraps at the end of a frame and swaps the data memory bank at that point. A processor port writes connection words and reads them back. Two global inputs, a drive enable and a standby bit, force every output driver off.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `out_oe`, `ctl_out`, `var_dly`, `out_data` and `cpu_rdata` are all zero, and the state machine is in `ST_HUNT`.
- R2: In `ST_HUNT`, a `slot_en` strobe without `fsync` is ignored and the outputs do not change. The first strobe with `fsync` is treated as channel 0 of frame 0.
- R3: In connection mode (word bit 12 = 0, bit 9 = 0), the output byte is the byte that the source stream carried in the source channel during the previous frame. In frame 0 after alignment this byte is 0.
- R3 (source field): With `rate_sel` = 0, the channel is word bits 2:0 and the stream is bits 4:3. With `rate_sel` = 1, the channel is bits 3:0 and the stream is bits 5:4.
- R4: Any number of output channels may name the same source, and all of them carry the same byte.
- R5: When word bit 12 is set (message mode), the output byte is word bits 7:0, repeated in every frame. Message mode takes priority over loopback.
- R6: When word bit 9 is set and bit 12 is clear (loopback), the output byte is the byte arriving on the same-numbered input stream in the same channel time.
- R7: `out_oe` of a stream follows word bit 10 of that stream's current channel. All per-stream outputs are registered on the edge that takes the strobe and are held until the next accepted strobe.
- R8: While `drv_en` is low or `standby` is low, every bit of `out_oe` is low in the same cycle, whatever the per-channel bits say.
- R9: `ctl_out` of a stream carries word bit 8 and `var_dly` carries word bit 11 for the current channel.
- R10: A frame has 8 channels when `rate_sel` = 0 and 16 when `rate_sel` = 1. After the last channel the count returns to 0 and the data memory banks swap.
- R11: A processor write to `cpu_addr` = {stream, channel} takes effect from the next channel time that reads that entry. `cpu_rdata` returns the word at `cpu_addr` one cycle later.
- R12: An `fsync` pulse that arrives while in `ST_RUN` is ignored, and channel counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One-cycle strobe that marks each channel time |
| fsync | input | 1 | Frame start, sampled with `slot_en` |
| rate_sel | input | 1 | 0: 8 channels per frame, 1: 16 channels per frame |
| drv_en | input | 1 | Global drive enable; low forces all drivers off |
| standby | input | 1 | Standby bit; low forces all drivers off |
| in_data | input | STREAMS*BYTE_W | Input bytes, stream s at bits [s*8 +: 8] |
| cpu_we | input | 1 | Connection memory write enable |
| cpu_addr | input | STR_W+CH_W | Connection memory address {stream, channel} |
| cpu_wdata | input | BYTE_W+5 | Connection word to write |
| cpu_rdata | output | BYTE_W+5 | Registered read of the connection word |
| out_data | output | STREAMS*BYTE_W | Output bytes, stream s at bits [s*8 +: 8] |
| out_oe | output | STREAMS | Per-stream driver enable |
| ctl_out | output | STREAMS | Per-stream control bit |
| var_dly | output | STREAMS | Per-stream delay-type flag |

## Verification
The bench uses the default parameters: 4 streams, a 3-bit base channel field and 8-bit bytes. With these, both rate settings fit inside an 8-bit source field, so the two source decodings of R3 are exercised with the same connection table. Only 8 or 16 channels per frame keep each frame short. Several frames can therefore be run in full, which brings into reach bank swapping, the zero output of the first frame, and a connection write between frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } tsi_state_e;

    // connection word control field positions
    localparam int BIT_MSG  = 12;
    localparam int BIT_VAR  = 11;
    localparam int BIT_OE   = 10;
    localparam int BIT_LOOP = 9;
    localparam int BIT_CTL  = 8;
endpackage

// File: rtl/tsi_slot_fsm.sv
module tsi_slot_fsm
    import tsi_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_en,
    input  logic            fsync,
    input  logic            rate_sel,
    output tsi_state_e      state,
    output logic            slot_go,
    output logic [CH_W-1:0] cur_ch,
    output logic [CH_W-1:0] last_ch,
    output logic            bank
);
    localparam int MAXCH = 1 << CH_W;

    tsi_state_e      state_q, state_d;
    logic [CH_W-1:0] ch_q;
    logic            bank_q;
    logic            wrap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (slot_en && fsync) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // state register and channel counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            ch_q    <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (slot_go) begin
                ch_q <= wrap ? '0 : cur_ch + 1'b1;
                if (wrap) bank_q <= ~bank_q;
            end
        end
    end

    // outputs
    always_comb begin
        last_ch = rate_sel ? CH_W'(MAXCH - 1) : CH_W'(MAXCH / 2 - 1);
        slot_go = 1'b0;
        cur_ch  = ch_q;
        unique case (state_q)
            ST_HUNT: begin
                slot_go = slot_en && fsync;
                cur_ch  = '0;
            end
            ST_RUN: slot_go = slot_en;
        endcase
        wrap  = (cur_ch >= last_ch);
        state = state_q;
        bank  = bank_q;
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int STREAMS = 4,
    parameter int CH_W    = 4,
    parameter int WORD_W  = 13,
    parameter int STR_W   = 2,
    parameter int AW      = STR_W + CH_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_we,
    input  logic [AW-1:0]                    cpu_addr,
    input  logic [WORD_W-1:0]                cpu_wdata,
    output logic [WORD_W-1:0]                cpu_rdata,
    input  logic [CH_W-1:0]                  cur_ch,
    output logic [STREAMS-1:0][WORD_W-1:0]   rd_words
);
    localparam int MAXCH = 1 << CH_W;

    logic [WORD_W-1:0] cm [STREAMS][MAXCH];
    logic [STR_W-1:0]  a_s;
    logic [CH_W-1:0]   a_c;

    assign a_s = cpu_addr[AW-1 -: STR_W];
    assign a_c = cpu_addr[CH_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STREAMS; s++)
                for (int c = 0; c < MAXCH; c++)
                    cm[s][c] <= '0;
            cpu_rdata <= '0;
        end else begin
            if (cpu_we) cm[a_s][a_c] <= cpu_wdata;
            cpu_rdata <= cm[a_s][a_c];
        end
    end

    for (genvar s = 0; s < STREAMS; s++) begin : g_rd
        assign rd_words[s] = cm[s][cur_ch];
    end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int STREAMS = 4,
    parameter int CH_W    = 4,
    parameter int BYTE_W  = 8,
    parameter int STR_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             slot_go,
    input  logic                             bank,
    input  logic [CH_W-1:0]                  cur_ch,
    input  logic [STREAMS-1:0][BYTE_W-1:0]   wr_bytes,
    input  logic [STREAMS-1:0][STR_W-1:0]    src_s,
    input  logic [STREAMS-1:0][CH_W-1:0]     src_c,
    output logic [STREAMS-1:0][BYTE_W-1:0]   rd_bytes
);
    localparam int MAXCH = 1 << CH_W;

    logic [BYTE_W-1:0] dm [2][STREAMS][MAXCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < STREAMS; s++)
                    for (int c = 0; c < MAXCH; c++)
                        dm[b][s][c] <= '0;
        end else if (slot_go) begin
            for (int s = 0; s < STREAMS; s++)
                dm[bank][s][cur_ch] <= wr_bytes[s];
        end
    end

    // reads come from the bank filled during the previous frame
    for (genvar s = 0; s < STREAMS; s++) begin : g_rd
        assign rd_bytes[s] = dm[~bank][src_s[s]][src_c[s]];
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int STREAMS = 4,
    parameter int CH_W0   = 3,
    parameter int BYTE_W  = 8,
    localparam int STR_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1,
    localparam int CH_W   = CH_W0 + 1,
    localparam int WORD_W = BYTE_W + 5,
    localparam int AW     = STR_W + CH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slot_en,
    input  logic                      fsync,
    input  logic                      rate_sel,
    input  logic                      drv_en,
    input  logic                      standby,
    input  logic [STREAMS*BYTE_W-1:0] in_data,
    input  logic                      cpu_we,
    input  logic [AW-1:0]             cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    output logic [WORD_W-1:0]         cpu_rdata,
    output logic [STREAMS*BYTE_W-1:0] out_data,
    output logic [STREAMS-1:0]        out_oe,
    output logic [STREAMS-1:0]        ctl_out,
    output logic [STREAMS-1:0]        var_dly
);
    tsi_state_e                     state;
    logic                           slot_go;
    logic                           bank;
    logic [CH_W-1:0]                cur_ch;
    logic [CH_W-1:0]                last_ch;
    logic [STREAMS-1:0][WORD_W-1:0] cm_rd;
    logic [STREAMS-1:0][BYTE_W-1:0] in_bytes;
    logic [STREAMS-1:0][BYTE_W-1:0] dm_rd;
    logic [STREAMS-1:0][STR_W-1:0]  src_s;
    logic [STREAMS-1:0][CH_W-1:0]   src_c;
    logic [STREAMS-1:0]             oe_q;
    logic                           glb_on;

    assign in_bytes = in_data;
    assign glb_on   = drv_en && standby;
    assign out_oe   = glb_on ? oe_q : '0;

    tsi_slot_fsm #(.CH_W(CH_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_en (slot_en),
        .fsync   (fsync),
        .rate_sel(rate_sel),
        .state   (state),
        .slot_go (slot_go),
        .cur_ch  (cur_ch),
        .last_ch (last_ch),
        .bank    (bank)
    );

    tsi_conn_mem #(
        .STREAMS(STREAMS), .CH_W(CH_W), .WORD_W(WORD_W), .STR_W(STR_W), .AW(AW)
    ) u_cm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cur_ch   (cur_ch),
        .rd_words (cm_rd)
    );

    tsi_data_mem #(
        .STREAMS(STREAMS), .CH_W(CH_W), .BYTE_W(BYTE_W), .STR_W(STR_W)
    ) u_dm (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_go (slot_go),
        .bank    (bank),
        .cur_ch  (cur_ch),
        .wr_bytes(in_bytes),
        .src_s   (src_s),
        .src_c   (src_c),
        .rd_bytes(dm_rd)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_out
        logic [WORD_W-1:0] w;
        logic [BYTE_W-1:0] sel;

        assign w = cm_rd[s];

        // source field packing depends on the channel count per frame
        always_comb begin
            if (rate_sel) begin
                src_c[s] = w[CH_W-1:0];
                src_s[s] = w[CH_W +: STR_W];
            end else begin
                src_c[s] = {1'b0, w[CH_W0-1:0]};
                src_s[s] = w[CH_W0 +: STR_W];
            end
        end

        always_comb begin
            if (w[BIT_MSG])       sel = w[BYTE_W-1:0];
            else if (w[BIT_LOOP]) sel = in_bytes[s];
            else                  sel = dm_rd[s];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_data[s*BYTE_W +: BYTE_W] <= '0;
                oe_q[s]    <= 1'b0;
                ctl_out[s] <= 1'b0;
                var_dly[s] <= 1'b0;
            end else if (slot_go) begin
                out_data[s*BYTE_W +: BYTE_W] <= sel;
                oe_q[s]    <= w[BIT_OE];
                ctl_out[s] <= w[BIT_CTL];
                var_dly[s] <= w[BIT_VAR];
            end
        end
    end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int STREAMS = 4,
    parameter int CH_W    = 4,
    parameter int BYTE_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input tsi_state_e                state,
    input logic                      slot_go,
    input logic [CH_W-1:0]           cur_ch,
    input logic [CH_W-1:0]           last_ch,
    input logic                      drv_en,
    input logic                      standby,
    input logic [STREAMS-1:0]        out_oe,
    input logic [STREAMS-1:0]        ctl_out,
    input logic [STREAMS*BYTE_W-1:0] out_data
);
    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (out_oe == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_go |=> ($stable(out_data) && $stable(ctl_out)));

    p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_en || !standby) |-> (out_oe == '0));

    p_chan_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cur_ch <= last_ch));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_go && cur_ch == last_ch) |=> (cur_ch == '0));
endmodule

bind tsi_switch tsi_switch_chk #(
    .STREAMS(STREAMS), .CH_W(CH_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .slot_go (slot_go),
    .cur_ch  (cur_ch),
    .last_ch (last_ch),
    .drv_en  (drv_en),
    .standby (standby),
    .out_oe  (out_oe),
    .ctl_out (ctl_out),
    .out_data(out_data)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0;
    logic        fsync = 1'b0;
    logic        rate_sel = 1'b0;
    logic        drv_en = 1'b1;
    logic        standby = 1'b1;
    logic [31:0] in_data = '0;
    logic        cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [12:0] cpu_wdata = '0;
    logic [12:0] cpu_rdata;
    logic [31:0] out_data;
    logic [3:0]  out_oe, ctl_out, var_dly;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [12:0] cm_m [NS][16];

    // {stream, channel, connection word}
    localparam logic [18:0] TBL [7] = '{
        {2'd0, 4'd0, 13'h040A},   // connection s1c2 (rate0), driven
        {2'd1, 4'd3, 13'h14A5},   // message A5, driven
        {2'd2, 4'd1, 13'h0700},   // loopback, driven, control bit
        {2'd3, 4'd5, 13'h040A},   // broadcast of the same source
        {2'd2, 4'd7, 13'h040A},   // broadcast again
        {2'd0, 4'd4, 13'h001F},   // connection, tristated
        {2'd1, 4'd6, 13'h1C33}    // message, variable delay flag
    };

    tsi_switch u_dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .fsync(fsync),
        .rate_sel(rate_sel), .drv_en(drv_en), .standby(standby),
        .in_data(in_data), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .out_data(out_data),
        .out_oe(out_oe), .ctl_out(ctl_out), .var_dly(var_dly)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return {f[1:0], s[1:0], c[3:0]};
    endfunction

    // {oe, ctl, var, byte} expected for one stream and channel
    function automatic logic [10:0] expect_out(input int f, input int s, input int c,
                                               input bit r);
        logic [12:0] w;
        logic [7:0]  b;
        int ss, cc;
        w = cm_m[s][c];
        if (w[12]) b = w[7:0];
        else if (w[9]) b = pat(f, s, c);
        else begin
            if (r) begin ss = int'(w[5:4]); cc = int'(w[3:0]); end
            else   begin ss = int'(w[4:3]); cc = int'(w[2:0]); end
            b = (f == 0) ? 8'h00 : pat(f - 1, ss, cc);
        end
        return {w[10], w[8], w[11], b};
    endfunction

    task automatic do_reset(input bit r);
        @(negedge clk);
        rst_n = 1'b0; rate_sel = r;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 16; c++) cm_m[s][c] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cpu_write(input int s, input int c, input logic [12:0] w);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = {s[1:0], c[3:0]}; cpu_wdata = w;
        @(negedge clk);
        cpu_we = 1'b0;
        cm_m[s][c] = w;
    endtask

    task automatic load_table();
        for (int i = 0; i < 7; i++) begin
            cpu_write(int'(TBL[i][18:17]), int'(TBL[i][16:13]), TBL[i][12:0]);
            @(negedge clk);
            check(cpu_rdata == TBL[i][12:0], "R11 readback", 32'(cpu_rdata),
                  32'(TBL[i][12:0]));
        end
    endtask

    task automatic slot(input int f, input int c, input bit fs);
        @(negedge clk);
        for (int s = 0; s < NS; s++) in_data[s*8 +: 8] = pat(f, s, c);
        slot_en = 1'b1; fsync = fs;
        @(negedge clk);
        slot_en = 1'b0; fsync = 1'b0;
    endtask

    // runs frames f0..f0+nf-1; fs_at pulses fsync mid-run in frame f0 (R12)
    task automatic run_frames(input bit r, input int f0, input int nf, input int fs_at);
        int nch;
        nch = r ? 16 : 8;
        for (int f = f0; f < f0 + nf; f++) begin
            for (int c = 0; c < nch; c++) begin
                slot(f, c, (f == 0 && c == 0) || (f == f0 && c == fs_at));
                for (int s = 0; s < NS; s++) begin
                    logic [10:0] e, a;
                    e = expect_out(f, s, c, r);
                    a = {out_oe[s], ctl_out[s], var_dly[s], out_data[s*8 +: 8]};
                    check(a == e, "R3/R4/R5/R6/R7/R9/R10/R12 slot output", 32'(a), 32'(e));
                end
            end
        end
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0);
        check(out_oe == 4'h0 && ctl_out == 4'h0 && var_dly == 4'h0, "R1 flags",
              {ctl_out, var_dly, out_oe}, 32'h0);
        check(out_data == 32'h0, "R1 data", out_data, 32'h0);
        check(cpu_rdata == 13'h0, "R1 cpu_rdata", 32'(cpu_rdata), 32'h0);

        load_table();

        // R2: strobes without fsync in the hunt state are ignored
        for (int i = 0; i < 3; i++) begin
            slot(3, 0, 1'b0);
            check(out_oe == 4'h0 && out_data == 32'h0, "R2 hunt ignores strobe",
                  {out_oe, out_data[27:0]}, 32'h0);
        end

        // rate 0: frame 0 reads zeros, frames 1..2 read previous frame (R3, R10)
        run_frames(1'b0, 0, 3, -1);

        // R8: global disable overrides per-channel enable (stream 2 driven at c7)
        check(out_oe[2] == 1'b1, "R7 enable held", 32'(out_oe), 32'h4);
        drv_en = 1'b0; #1;
        check(out_oe == 4'h0, "R8 drv_en low", 32'(out_oe), 32'h0);
        drv_en = 1'b1; standby = 1'b0; #1;
        check(out_oe == 4'h0, "R8 standby low", 32'(out_oe), 32'h0);
        standby = 1'b1; #1;
        check(out_oe[2] == 1'b1, "R8 restored", 32'(out_oe), 32'h4);

        // R11: a connection write between frames applies next frame
        cpu_write(1, 3, 13'h145A);
        // R12: fsync at channel 2 of frame 3 is ignored
        run_frames(1'b0, 3, 1, 2);

        // rate 1: 16 channels per frame with the wider source field (R3, R10)
        do_reset(1'b1);
        load_table();
        run_frames(1'b1, 0, 2, -1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule